// File: doc/BRIEF.md
# Asynchronous CPU Bus Register Access Unit

This block sits between a processor bus and the register file of a two-channel serial controller. The processor drives active-low chip enable, read and write strobes that have no timing relationship to the controller clock. It also drives a data/control port select, a channel select and an active-low interrupt-acknowledge line. The strobes are brought into the clock domain through a two-flop synchronizer. The synchronized start of each access produces one internal access strobe, and the port and channel selects are latched in that same cycle. A register pointer selects which control register a control-port access reaches. A fixed recovery interval, counted in clock cycles, then keeps the next access out.

Read data leaves the block as a byte plus an output enable. The enable follows the live chip-enable and read pins, so the surrounding pad logic can place the byte on a shared three-state bus. The register file is a small demonstration store: one data register per channel and sixteen control registers per channel. Control register 0 is never stored. A write to it loads the pointer instead.

There is no flow control on this interface. The processor paces itself by respecting the recovery interval, and accesses that arrive too early are silently dropped.

Top module: `cpu_bus_regif`

## Requirements
- R1: After reset, `ptr` is 0, `busy` is 0, `acc_stb` is 0, and every stored register reads 0.
- R2: An access begins when `cs_n` and one of `rd_n`/`wr_n` are low together. Whichever of the two falls later marks the start. An accepted access raises `acc_stb` for exactly one cycle, on the third rising edge that samples the coincidence. A strobe held low produces no further pulses.
- R3: In the cycle `acc_stb` is high, `acc_wr` is 1 for a write and 0 for a read. In the same cycle `acc_dc` and `acc_ch` hold the values `dc_sel` and `ch_sel` had at acceptance.
- R4: An access is performed only if `ack_n` was high at the rising edge before the one that accepts it. Otherwise there is no `acc_stb` and no register changes.
- R5: `rd_oe` is 1 exactly while `cs_n` and `rd_n` are both low. During that time `rdata` shows the selected register: the data register of `ch_sel` when `dc_sel`=1, or control register `ptr` of `ch_sel` when `dc_sel`=0.
- R6: A data-port access (`dc_sel`=1) reads or writes the data register of the selected channel and leaves `ptr` unchanged.
- R7: A control-port write (`dc_sel`=0) made while `ptr` is 0 loads `ptr` from `wdata[3:0]` and stores nothing.
- R8: Any other control-port access reads or writes control register `ptr` of the selected channel, then sets `ptr` to 0. The two channels keep separate control registers.
- R9: After acceptance, `busy` is 1 for four cycles. It rises together with `acc_stb`. An access whose synchronized start falls while `busy` is 1 is dropped. The first start detected after `busy` falls is honoured.
- R10: `rd_n`/`wr_n` activity while `cs_n` is high causes no access and does not extend `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip enable, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| dc_sel | input | 1 | 1 = data port, 0 = control port |
| ch_sel | input | 1 | Channel select |
| ack_n | input | 1 | Interrupt acknowledge, active low; blocks accesses |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selected register value |
| rd_oe | output | 1 | Bus output enable for rdata |
| acc_stb | output | 1 | One-cycle internal access strobe |
| acc_wr | output | 1 | Latched direction (1 = write) |
| acc_dc | output | 1 | Latched port select |
| acc_ch | output | 1 | Latched channel select |
| ptr | output | 4 | Register pointer |
| busy | output | 1 | Recovery interval in progress |

## Verification
The bench delivers a second access whose synchronized start lands inside the recovery window, then a third that starts one cycle after the window closes. A counter that loaded the wrong length, or that counted from the wrong cycle, would accept the second access or drop the third. In one test chip enable falls after the read strobe. If the start were taken from the strobe alone, that access would be lost, or it would fire with the output enable wrong. Strobe toggles with chip enable high are aimed at the middle of a recovery window, and `busy` must still fall on schedule. The pointer is loaded, used and then checked against both ports. A design that cleared the pointer on data accesses, or failed to clear it after a control access, shows a wrong `ptr` or reads back the wrong byte.

// File: rtl/regif_pkg.sv
package regif_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          wr;
    logic          dc;
    logic          ch;
    logic [DW-1:0] data;
  } regif_req_t;
endpackage

// File: rtl/regif_strobe_sync.sv
module regif_strobe_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_act,
  output logic [N-1:0] start
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], raw_act[g]};
      end
      assign start[g] = sh[STAGES-1] & ~sh[STAGES];

      a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start[g] |=> !start[g]);
    end
  endgenerate
endmodule

// File: rtl/regif_recovery.sv
module regif_recovery #(
  parameter int RECOVERY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(RECOVERY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (go)         cnt <= CW'(RECOVERY_CYC);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end
  assign busy = (cnt != '0);

  a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CW'(1)) && !$past(go));
endmodule

// File: rtl/regif_regfile.sv
module regif_regfile
  import regif_pkg::*;
#(
  parameter int NREG = 16,
  parameter int PW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  regif_req_t    req,
  input  logic          sel_dc,
  input  logic          sel_ch,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] ptr
);
  localparam int NCH = 2;

  logic [DW-1:0] creg [NCH][NREG];
  logic [DW-1:0] dreg [NCH];
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        dreg[c] <= '0;
        for (int r = 0; r < NREG; r++) creg[c][r] <= '0;
      end
    end else if (go) begin
      if (req.dc) begin
        if (req.wr) dreg[req.ch] <= req.data;
      end else if (req.wr && ptr_q == '0) begin
        ptr_q <= req.data[PW-1:0];
      end else begin
        if (req.wr) creg[req.ch][ptr_q] <= req.data;
        ptr_q <= '0;
      end
    end
  end

  assign rd_data = sel_dc ? dreg[sel_ch] : creg[sel_ch][ptr_q];
  assign ptr     = ptr_q;

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    go && req.dc |=> ptr_q == $past(ptr_q));
  a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    go && !req.dc && req.wr && ptr_q == '0 |=> ptr_q == $past(req.data[PW-1:0]));
  a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    go && !req.dc && !(req.wr && ptr_q == '0) |=> ptr_q == '0);
endmodule

// File: rtl/cpu_bus_regif.sv
module cpu_bus_regif
  import regif_pkg::*;
#(
  parameter int NREG         = 16,
  parameter int RECOVERY_CYC = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dc_sel,
  input  logic          ch_sel,
  input  logic          ack_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_oe,
  output logic          acc_stb,
  output logic          acc_wr,
  output logic          acc_dc,
  output logic          acc_ch,
  output logic [3:0]    ptr,
  output logic          busy
);
  localparam int PW = $clog2(NREG);

  logic [1:0]    raw_act, edge_start;
  logic          ack_ok, go;
  regif_req_t    req;
  logic [PW-1:0] ptr_i;

  assign raw_act = {~cs_n & ~wr_n, ~cs_n & ~rd_n};

  regif_strobe_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_act(raw_act), .start(edge_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_ok <= 1'b0;
    else        ack_ok <= ack_n;
  end

  assign go = (|edge_start) & ack_ok & ~busy;

  always_comb begin
    req.wr   = edge_start[1] & ~edge_start[0];
    req.dc   = dc_sel;
    req.ch   = ch_sel;
    req.data = wdata;
  end

  regif_recovery #(.RECOVERY_CYC(RECOVERY_CYC)) u_recov (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy));

  regif_regfile #(.NREG(NREG), .PW(PW)) u_rf (
    .clk(clk), .rst_n(rst_n), .go(go), .req(req),
    .sel_dc(dc_sel), .sel_ch(ch_sel), .rd_data(rdata), .ptr(ptr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_stb <= 1'b0;
      acc_wr  <= 1'b0;
      acc_dc  <= 1'b0;
      acc_ch  <= 1'b0;
    end else begin
      acc_stb <= go;
      if (go) begin
        acc_wr <= req.wr;
        acc_dc <= req.dc;
        acc_ch <= req.ch;
      end
    end
  end

  assign rd_oe = ~cs_n & ~rd_n;
  assign ptr   = 4'(ptr_i);

  a_r2_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> !acc_stb);
  a_r9_busy_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> busy);
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> !$past(busy));
  a_r4_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> $past(ack_n, 2));
endmodule

// File: tb/tb_cpu_bus_regif.sv
module tb_cpu_bus_regif;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dc_sel = 1'b0, ch_sel = 1'b0, ack_n = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic rd_oe, acc_stb, acc_wr, acc_dc, acc_ch, busy;
  logic [3:0] ptr;

  cpu_bus_regif dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic l_wr, l_dc, l_ch;

  always @(posedge clk) begin
    #2;
    if (acc_stb) begin
      stb_cnt++; l_wr = acc_wr; l_dc = acc_dc; l_ch = acc_ch;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic dc, input logic ch,
                        input logic [7:0] d, output logic [7:0] rv);
    @(negedge clk);
    dc_sel = dc; ch_sel = ch; wdata = d; cs_n = 1'b0;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk); rv = rdata;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ptr", ptr, 0); chk("R1 busy", busy, 0);
    chk("R1 acc_stb", acc_stb, 0); chk("R1 rd_oe", rd_oe, 0);
  endtask

  task automatic t_pointer();
    logic [7:0] rv; int s0;
    s0 = stb_cnt;
    bus_op(1, 0, 0, 8'h05, rv);
    chk("R7 ptr load", ptr, 5);
    chk("R2 one stb", stb_cnt - s0, 1);
    chk("R3 wr/dc/ch", {l_wr, l_dc, l_ch}, 3'b100);
    bus_op(1, 0, 0, 8'hA5, rv);
    chk("R8 ptr cleared after write", ptr, 0);
    bus_op(1, 0, 1, 8'h05, rv);
    bus_op(1, 0, 1, 8'h3C, rv);
    bus_op(1, 0, 0, 8'h05, rv);
    bus_op(0, 0, 0, 8'h00, rv);
    chk("R8 ch0 reg5 readback", rv, 8'hA5);
    chk("R3 read latched", {l_wr, l_dc, l_ch}, 3'b000);
    chk("R8 ptr cleared after read", ptr, 0);
    bus_op(1, 0, 1, 8'h05, rv);
    bus_op(0, 0, 1, 8'h00, rv);
    chk("R8 ch1 reg5 separate", rv, 8'h3C);
  endtask

  task automatic t_data_port();
    logic [7:0] rv;
    bus_op(1, 0, 0, 8'h07, rv);
    bus_op(1, 1, 1, 8'h6E, rv);
    chk("R6 ptr kept on data write", ptr, 7);
    chk("R3 data latched", {l_wr, l_dc, l_ch}, 3'b111);
    bus_op(0, 1, 1, 8'h00, rv);
    chk("R6 data readback", rv, 8'h6E);
    chk("R6 ptr kept on data read", ptr, 7);
    bus_op(0, 1, 0, 8'h00, rv);
    chk("R6 ch0 data untouched", rv, 8'h00);
    bus_op(0, 0, 0, 8'h00, rv);
    chk("R8 ptr cleared", ptr, 0);
  endtask

  task automatic t_intack();
    logic [7:0] rv; int s0;
    ack_n = 1'b0; s0 = stb_cnt;
    bus_op(1, 1, 1, 8'h11, rv);
    chk("R4 no stb while ack low", stb_cnt - s0, 0);
    ack_n = 1'b1;
    bus_op(0, 1, 1, 8'h00, rv);
    chk("R4 register unchanged", rv, 8'h6E);
  endtask

  task automatic t_late_ce();
    int s0;
    s0 = stb_cnt;
    @(negedge clk); dc_sel = 1'b1; ch_sel = 1'b1; rd_n = 1'b0;
    #1 chk("R5 no oe without cs", rd_oe, 0);
    repeat (3) @(negedge clk);
    chk("R2 no stb without cs", stb_cnt - s0, 0);
    cs_n = 1'b0;
    #1 chk("R5 oe with cs and rd", rd_oe, 1);
    chk("R5 rdata selected", rdata, 8'h6E);
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    #1 chk("R5 oe drops", rd_oe, 0);
    repeat (6) @(negedge clk);
    chk("R2 late cs accepted once", stb_cnt - s0, 1);
  endtask

  task automatic t_recovery();
    int s0;
    s0 = stb_cnt;
    @(negedge clk); dc_sel = 1'b1; ch_sel = 1'b0; wdata = 8'h21; cs_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R9 busy after accept", busy, 1);
    chk("R2 stb on third edge", stb_cnt - s0, 1);
    wdata = 8'h99; cs_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R9 busy last cycle", busy, 1);
    wdata = 8'h42; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    chk("R9 busy falls after four", busy, 0);
    chk("R9 early access dropped", stb_cnt - s0, 1);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 access after window honoured", stb_cnt - s0, 2);
    cs_n = 1'b0; rd_n = 1'b0;
    #1 chk("R9 last write wins", rdata, 8'h42);
    repeat (2) @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_ce_high();
    int s0;
    s0 = stb_cnt;
    @(negedge clk); dc_sel = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    chk("R10 busy still on", busy, 1);
    @(negedge clk);
    chk("R10 busy not extended", busy, 0);
    repeat (6) @(negedge clk);
    chk("R10 no access from cs-high strobes", stb_cnt - s0, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pointer();
    t_data_port();
    t_intack();
    t_late_ce();
    t_recovery();
    t_ce_high();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule